// File: doc/BRIEF.md
# Floating-Point Conditional Commit Unit

This block decides, once per issued instruction, whether a conditionally executed floating-point operation is allowed to retire. It evaluates a selected predicate against the floating-point condition flags it holds. It also decides whether the predicate allows the operation to write its arithmetic result, its parallel register move and its status updates. The predicates are IEEE-aware: they include ordered and unordered relations and a NaN test. Testing a relation while the NaN flag is up leaves a sticky mark in two places, whether or not the predicate turns out true.

The unit holds three status registers: the condition flags, the exception register and the trap-status register. The arithmetic unit supplies the values these registers would take if the operation commits. The unit raises the write enables combinationally in the cycle the instruction is valid, and the registers take their new values on the next rising clock edge. Commit therefore completes in one cycle.

Top module: `fp_cond_commit`

## Requirements
- R1: The condition select uses these codes: 0 EQ (Z=1), 1 NE (Z=0), 2 MI (N=1), 3 PL (N=0), 4 OR (NAN=0), 5 UN (NAN=1), 6 INF (I=1) and 7 NINF (I=0). The flags register is laid out as bit0 Z, bit1 N, bit2 I and bit3 NAN.
- R2: The ordered relations use odd codes: 9 GE, 11 GT, 13 LE, 15 LT, 17 GL and 19 GLE. Each is true when its term is 0. The terms are NAN|(N&~Z) for GE, NAN|Z|N for GT, NAN|~(N|Z) for LE, NAN|Z|~N for LT, NAN|Z for GL and NAN for GLE.
- R3: Codes 10 NGE, 12 NGT, 14 NLE, 16 NLT, 18 NGL and 20 NGLE are the exact complements of the codes one below them. Each is true when the same term is 1.
- R4: Code 8 (ERR) is true when any of exception-register bits 0 to 5 is set. Those bits are, in order: unordered-compare, signalling NaN, operand error, overflow, underflow and divide-by-zero. The flags register plays no part in ERR.
- R5: With the instruction valid and the condition true, resultWe and moveWe are both high in that cycle. On the next edge the flags, exception and trap-status registers load newFlags, newExc and newTrap.
- R6: With the instruction valid and the condition false, both enables stay low. The flags register holds its value, and the other two registers change only through the sticky rule of R7 and R9.
- R7: If NAN is set when a valid instruction tests codes 6, 7 or 9 to 20, exception bit 0 and trap-status bit 0 are set on the next edge. This happens whatever the truth of the condition.
- R8: Codes 0 to 5 and 8 never set exception bit 0 or trap-status bit 0 on their own, even with NAN set.
- R9: Exception bit 0 and trap-status bit 0 are sticky. A commit whose new value has bit 0 clear leaves a set bit 0 set. Only reset or clrSticky clears them. When clrSticky and a raise from R7 occur in the same cycle, the bits end up set.
- R10: Codes 21 to 31 evaluate as false and raise nothing.
- R11: With instValid low, both enables are low and no register changes, apart from the clearing done by clrSticky.
- R12: A synchronous active-high reset clears all three registers. Both enables are low while reset is held with instValid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | An instruction is presented this cycle |
| condSel | input | 5 | Condition code |
| clrSticky | input | 1 | Clears exception bit 0 and trap-status bit 0 |
| newFlags | input | 4 | Flags produced by the operation |
| newExc | input | EXC_W (6) | Exception bits produced by the operation |
| newTrap | input | TRAP_W (4) | Trap-status bits produced by the operation |
| resultWe | output | 1 | Write enable for the arithmetic result |
| moveWe | output | 1 | Write enable for the parallel register move |
| flagsQ | output | 4 | Current condition flags |
| excQ | output | EXC_W (6) | Current exception register |
| trapQ | output | TRAP_W (4) | Current trap-status register |

## Verification
The hardest case to reach is one where the sticky rule meets a commit in the same cycle. An example is a true condition whose new exception value has bit 0 clear while bit 0 is already set, or a clear strobe arriving together with a NaN-raising test. The only way to set NAN is to commit it through the instruction path. The bench therefore loads flags with EQ or NE, whichever is true at that moment, since neither can raise the sticky bits. It then stacks a NaN-aware probe, a committing NE, a bare clear and a clear combined with a GLE test. The bench also sweeps all 32 codes over all 16 flag patterns and finishes with random instructions against a scoreboard model.

// File: rtl/fp_cond_pkg.sv
package fp_cond_pkg;
  localparam int CODE_W = 5;
  localparam int FLAG_W = 4;
  localparam int Z_BIT = 0;
  localparam int N_BIT = 1;
  localparam int I_BIT = 2;
  localparam int NAN_BIT = 3;
  localparam int ERR_SRC_W = 6;
  localparam int UNORD_BIT = 0;
  localparam int INVOP_BIT = 0;

  typedef enum logic [CODE_W-1:0] {
    C_EQ = 5'd0, C_NE, C_MI, C_PL, C_ORD, C_UNORD, C_INF, C_NINF, C_ERR,
    C_GE, C_NGE, C_GT, C_NGT, C_LE, C_NLE, C_LT, C_NLT,
    C_GL, C_NGL, C_GLE, C_NGLE
  } cond_e;

  typedef struct packed {
    logic commit;
    logic raiseUn;
    logic clearSticky;
  } strobe_t;
endpackage

// File: rtl/fp_cond_control.sv
module fp_cond_control
  import fp_cond_pkg::*;
#(
  parameter int EXC_W = 6
) (
  input  logic              instValid,
  input  logic [CODE_W-1:0] condSel,
  input  logic              clrSticky,
  input  logic [FLAG_W-1:0] flagsQ,
  input  logic [EXC_W-1:0]  excQ,
  output strobe_t           strobes
);
  logic z, n, inf, nan, errAny;
  logic geTerm, gtTerm, leTerm, ltTerm, glTerm, gleTerm;
  logic condTrue, aware;

  assign z   = flagsQ[Z_BIT];
  assign n   = flagsQ[N_BIT];
  assign inf = flagsQ[I_BIT];
  assign nan = flagsQ[NAN_BIT];
  assign errAny = |excQ[ERR_SRC_W-1:0];

  assign geTerm  = nan | (n & ~z);
  assign gtTerm  = nan | z | n;
  assign leTerm  = nan | ~(n | z);
  assign ltTerm  = nan | z | ~n;
  assign glTerm  = nan | z;
  assign gleTerm = nan;

  always_comb begin
    condTrue = 1'b0;
    aware    = 1'b0;
    case (condSel)
      C_EQ:    condTrue = z;
      C_NE:    condTrue = ~z;
      C_MI:    condTrue = n;
      C_PL:    condTrue = ~n;
      C_ORD:   condTrue = ~nan;
      C_UNORD: condTrue = nan;
      C_ERR:   condTrue = errAny;
      C_INF:   begin condTrue = inf;      aware = 1'b1; end
      C_NINF:  begin condTrue = ~inf;     aware = 1'b1; end
      C_GE:    begin condTrue = ~geTerm;  aware = 1'b1; end
      C_NGE:   begin condTrue = geTerm;   aware = 1'b1; end
      C_GT:    begin condTrue = ~gtTerm;  aware = 1'b1; end
      C_NGT:   begin condTrue = gtTerm;   aware = 1'b1; end
      C_LE:    begin condTrue = ~leTerm;  aware = 1'b1; end
      C_NLE:   begin condTrue = leTerm;   aware = 1'b1; end
      C_LT:    begin condTrue = ~ltTerm;  aware = 1'b1; end
      C_NLT:   begin condTrue = ltTerm;   aware = 1'b1; end
      C_GL:    begin condTrue = ~glTerm;  aware = 1'b1; end
      C_NGL:   begin condTrue = glTerm;   aware = 1'b1; end
      C_GLE:   begin condTrue = ~gleTerm; aware = 1'b1; end
      C_NGLE:  begin condTrue = gleTerm;  aware = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    strobes.commit      = instValid & condTrue;
    strobes.raiseUn     = instValid & nan & aware;
    strobes.clearSticky = clrSticky;
  end
endmodule

// File: rtl/fp_cond_datapath.sv
module fp_cond_datapath
  import fp_cond_pkg::*;
#(
  parameter int EXC_W  = 6,
  parameter int TRAP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [FLAG_W-1:0] newFlags,
  input  logic [EXC_W-1:0]  newExc,
  input  logic [TRAP_W-1:0] newTrap,
  output logic [FLAG_W-1:0] flagsQ,
  output logic [EXC_W-1:0]  excQ,
  output logic [TRAP_W-1:0] trapQ
);
  logic excStickyNext, trapStickyNext;

  assign excStickyNext  = (strobes.clearSticky ? 1'b0 : excQ[UNORD_BIT])
                        | (strobes.commit & newExc[UNORD_BIT])
                        | strobes.raiseUn;
  assign trapStickyNext = (strobes.clearSticky ? 1'b0 : trapQ[INVOP_BIT])
                        | (strobes.commit & newTrap[INVOP_BIT])
                        | strobes.raiseUn;

  always_ff @(posedge clk) begin
    if (rst) begin
      flagsQ <= '0;
      excQ   <= '0;
      trapQ  <= '0;
    end else begin
      if (strobes.commit) begin
        flagsQ <= newFlags;
        excQ   <= newExc;
        trapQ  <= newTrap;
      end
      excQ[UNORD_BIT]  <= excStickyNext;
      trapQ[INVOP_BIT] <= trapStickyNext;
    end
  end
endmodule

// File: rtl/fp_cond_commit.sv
module fp_cond_commit
  import fp_cond_pkg::*;
#(
  parameter int EXC_W  = 6,
  parameter int TRAP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [CODE_W-1:0] condSel,
  input  logic              clrSticky,
  input  logic [FLAG_W-1:0] newFlags,
  input  logic [EXC_W-1:0]  newExc,
  input  logic [TRAP_W-1:0] newTrap,
  output logic              resultWe,
  output logic              moveWe,
  output logic [FLAG_W-1:0] flagsQ,
  output logic [EXC_W-1:0]  excQ,
  output logic [TRAP_W-1:0] trapQ
);
  strobe_t strobes;

  fp_cond_control #(.EXC_W(EXC_W)) u_ctrl (
    .instValid(instValid), .condSel(condSel), .clrSticky(clrSticky),
    .flagsQ(flagsQ), .excQ(excQ), .strobes(strobes)
  );

  fp_cond_datapath #(.EXC_W(EXC_W), .TRAP_W(TRAP_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .newFlags(newFlags), .newExc(newExc), .newTrap(newTrap),
    .flagsQ(flagsQ), .excQ(excQ), .trapQ(trapQ)
  );

  assign resultWe = strobes.commit;
  assign moveWe   = strobes.commit;
endmodule

// File: rtl/fp_cond_commit_chk.sv
module fp_cond_commit_chk
  import fp_cond_pkg::*;
#(
  parameter int EXC_W  = 6,
  parameter int TRAP_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              instValid,
  input logic [CODE_W-1:0] condSel,
  input logic              clrSticky,
  input logic              resultWe,
  input logic              moveWe,
  input logic [FLAG_W-1:0] flagsQ,
  input logic [EXC_W-1:0]  excQ,
  input logic [TRAP_W-1:0] trapQ
);
  // R5
  we_pair_chk: assert property (@(posedge clk) disable iff (rst)
    resultWe == moveWe);

  // R11
  valid_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> !resultWe);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!instValid && !clrSticky) |=> ($stable(flagsQ) && $stable(excQ) && $stable(trapQ)));

  // R6
  false_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (instValid && !resultWe) |=> $stable(flagsQ));

  // R9
  exc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (excQ[UNORD_BIT] && !clrSticky) |=> excQ[UNORD_BIT]);

  // R9
  trap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (trapQ[INVOP_BIT] && !clrSticky) |=> trapQ[INVOP_BIT]);

  // R10
  unused_false_chk: assert property (@(posedge clk) disable iff (rst)
    (instValid && condSel > 5'd20) |-> !resultWe);

  // R10
  unused_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (instValid && condSel > 5'd20 && !clrSticky) |=> ($stable(excQ) && $stable(trapQ)));

  // R1
  eq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (instValid && condSel == 5'd0) |-> (resultWe == flagsQ[Z_BIT]));

  // R7
  nan_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (instValid && flagsQ[NAN_BIT] && condSel == 5'd19) |=> (excQ[UNORD_BIT] && trapQ[INVOP_BIT]));
endmodule

bind fp_cond_commit fp_cond_commit_chk #(.EXC_W(EXC_W), .TRAP_W(TRAP_W)) u_chk (
  .clk(clk), .rst(rst), .instValid(instValid), .condSel(condSel),
  .clrSticky(clrSticky), .resultWe(resultWe), .moveWe(moveWe),
  .flagsQ(flagsQ), .excQ(excQ), .trapQ(trapQ)
);

// File: tb/fp_cond_commit_bench.sv
`timescale 1ns/1ps
module fp_cond_commit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instValid = 1'b0;
  logic [4:0] condSel = '0;
  logic clrSticky = 1'b0;
  logic [3:0] newFlags = '0;
  logic [5:0] newExc = '0;
  logic [3:0] newTrap = '0;
  logic resultWe, moveWe;
  logic [3:0] flagsQ;
  logic [5:0] excQ;
  logic [3:0] trapQ;

  always #4 clk = ~clk;

  fp_cond_commit u_fp_cond_commit (
    .clk(clk), .rst(rst), .instValid(instValid), .condSel(condSel),
    .clrSticky(clrSticky), .newFlags(newFlags), .newExc(newExc), .newTrap(newTrap),
    .resultWe(resultWe), .moveWe(moveWe), .flagsQ(flagsQ), .excQ(excQ), .trapQ(trapQ)
  );

  typedef struct {
    logic       we;
    logic [3:0] flags;
    logic [5:0] exc;
    logic [3:0] trap;
    string      tagWe;
    string      tagReg;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  logic [3:0] mFlags = '0;
  logic [5:0] mExc = '0;
  logic [3:0] mTrap = '0;

  function automatic logic expTrue(int c, logic [3:0] f, logic [5:0] e);
    logic z, n, i, q;
    z = f[0]; n = f[1]; i = f[2]; q = f[3];
    case (c)
      0: return z;
      1: return !z;
      2: return n;
      3: return !n;
      4: return !q;
      5: return q;
      6: return i;
      7: return !i;
      8: return e != 6'd0;
      9:  return (q || (n && !z)) == 1'b0;
      10: return (q || (n && !z)) == 1'b1;
      11: return (q || z || n) == 1'b0;
      12: return (q || z || n) == 1'b1;
      13: return (q || !(n || z)) == 1'b0;
      14: return (q || !(n || z)) == 1'b1;
      15: return (q || z || !n) == 1'b0;
      16: return (q || z || !n) == 1'b1;
      17: return (q || z) == 1'b0;
      18: return (q || z) == 1'b1;
      19: return q == 1'b0;
      20: return q == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic expAware(int c);
    return (c == 6) || (c == 7) || (c >= 9 && c <= 20);
  endfunction

  function automatic string tagFor(int c);
    if (c <= 7) return "R1";
    if (c == 8) return "R4";
    if (c > 20) return "R10";
    return (c % 2 == 1) ? "R2" : "R3";
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic v, input int c, input logic [3:0] nf,
                       input logic [5:0] ne, input logic [3:0] nt, input logic clr,
                       input string tw, input string tr);
    item_t it;
    logic take, raise, s0e, s0t;
    @(negedge clk);
    instValid = v; condSel = c[4:0]; newFlags = nf; newExc = ne; newTrap = nt;
    clrSticky = clr;
    take  = v && expTrue(c, mFlags, mExc);
    raise = v && mFlags[3] && expAware(c);
    s0e = (clr ? 1'b0 : mExc[0]) | (take & ne[0]) | raise;
    s0t = (clr ? 1'b0 : mTrap[0]) | (take & nt[0]) | raise;
    if (take) begin mFlags = nf; mExc = ne; mTrap = nt; end
    mExc[0] = s0e;
    mTrap[0] = s0t;
    it.we = take; it.flags = mFlags; it.exc = mExc; it.trap = mTrap;
    it.tagWe = tw; it.tagReg = tr;
    sbq.push_back(it);
  endtask

  task automatic probe(input int c);
    string tr;
    if (mFlags[3] && expAware(c)) tr = "R7";
    else if (mFlags[3] && (c <= 5 || c == 8)) tr = "R8";
    else tr = tagFor(c);
    issue(1'b1, c, mFlags, mExc, mTrap, 1'b0, tagFor(c), tr);
  endtask

  // EQ or NE, whichever is true now; neither can raise the sticky bits
  task automatic loadFlags(input logic [3:0] f, input logic [5:0] e, input logic [3:0] t);
    issue(1'b1, mFlags[0] ? 0 : 1, f, e, t, 1'b1, "R1", "R5");
  endtask

  // scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check(resultWe === it.we && moveWe === it.we, it.tagWe, "enables",
              {30'd0, resultWe, moveWe}, {30'd0, it.we, it.we});
        @(posedge clk);
        #1;
        check(flagsQ === it.flags && excQ === it.exc && trapQ === it.trap, it.tagReg,
              "registers", {18'd0, flagsQ, excQ, trapQ}, {18'd0, it.flags, it.exc, it.trap});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL all requirements: watchdog expired, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check(resultWe === 1'b0 && moveWe === 1'b0, "R12", "enables in reset",
          {30'd0, resultWe, moveWe}, 32'd0);
    check(flagsQ === 4'd0 && excQ === 6'd0 && trapQ === 4'd0, "R12", "registers in reset",
          {18'd0, flagsQ, excQ, trapQ}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R3 R10: every code over every flag pattern
    for (int f = 0; f < 16; f++) begin
      loadFlags(f[3:0], 6'd0, 4'd0);
      for (int c = 0; c < 32; c++) probe(c);
    end

    // R4: ERR looks at each exception bit, not at the flags
    for (int b = 0; b < 6; b++) begin
      loadFlags(4'b0000, 6'(1 << b), 4'd0);
      probe(8);
    end
    loadFlags(4'b1111, 6'd0, 4'd0);
    probe(8);

    // R5: true condition loads all three registers
    loadFlags(4'b0000, 6'd0, 4'd0);
    issue(1'b1, 11, 4'b1010, 6'b101100, 4'b1110, 1'b0, "R5", "R5");
    // R6 R7: GT false with NAN set, raises sticky bits only
    issue(1'b1, 11, 4'b0001, 6'b010010, 4'b0110, 1'b0, "R6", "R7");
    // R6: GE false with N set
    loadFlags(4'b0010, 6'd0, 4'd0);
    issue(1'b1, 9, 4'b1111, 6'b111110, 4'b1111, 1'b0, "R6", "R6");

    // R9: sticky behaviour around commits and clears
    loadFlags(4'b1000, 6'd0, 4'd0);
    probe(17);
    issue(1'b1, 1, 4'b1000, 6'b000000, 4'b0000, 1'b0, "R9", "R9");
    issue(1'b0, 0, 4'd0, 6'd0, 4'd0, 1'b1, "R11", "R9");
    issue(1'b1, 19, 4'd0, 6'd0, 4'd0, 1'b1, "R9", "R9");
    // R8: non-aware tests with NAN set after a clear
    issue(1'b0, 0, 4'd0, 6'd0, 4'd0, 1'b1, "R11", "R9");
    probe(5);
    probe(4);
    // R11: idle with a code that would raise
    issue(1'b0, 19, 4'b0101, 6'b111111, 4'b1111, 1'b0, "R11", "R11");

    // random mix
    for (int k = 0; k < 400; k++) begin
      int c;
      logic v, clr;
      c = int'($urandom % 32);
      v = ($urandom % 4) != 0;
      clr = ($urandom % 8) == 0;
      issue(v, c, 4'($urandom), 6'($urandom), 4'($urandom), clr,
            v ? tagFor(c) : "R11", "R5");
    end
    issue(1'b0, 0, 4'd0, 6'd0, 4'd0, 1'b0, "R11", "R11");

    wait (sbq.size() == 0);
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule